// File: doc/BRIEF.md
# Sparse Three-Code Address Decoder with AND-OR Selector

This block looks at a 3-bit address and recognises exactly three of its eight values: 3, 6 and 7. Each recognised value drives its own enable line, so the enable vector is one-hot on a mapped address and all zero on the other five. The enables then gate three single-bit data inputs into a 1-bit result. Each enable is ANDed with its data bit and the three products are ORed together, so an unmapped address always yields a zero result.

The block is purely combinational. It has no clock and no reset. Both the enable vector and the selected bit appear at the ports, so a neighbour can use the decode alone or the multiplexed bit. The set of recognised codes is a parameter, and elaboration checks that the codes are distinct and fit the address. The defaults give the 3/6/7 map.

Top module: `sprs_dec_mux`

## Requirements
- R1: With addr_i = 3'b011, en_o is 3'b001 (bit 0 is the lane for code 3).
- R2: With addr_i = 3'b110, en_o is 3'b010 (bit 1 is the lane for code 6).
- R3: With addr_i = 3'b111, en_o is 3'b100 (bit 2 is the lane for code 7).
- R4: For every address value, at most one bit of en_o is 1.
- R5: For addresses 0, 1, 2, 4 and 5, en_o is 3'b000 and mux_o is 0, whatever dat_i holds.
- R6: mux_o equals dat_i[0] at address 3, dat_i[1] at address 6 and dat_i[2] at address 7.
- R7: On a mapped address, the two data bits that are not selected have no effect on mux_o.
- R8: addr_i[2] is the most significant address bit and addr_i[0] the least significant, so 3'b001 and 3'b100 are both unmapped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| addr_i | input | 3 | Address, bit 2 most significant |
| dat_i | input | 3 | Data lanes; bit 0 for code 3, bit 1 for code 6, bit 2 for code 7 |
| en_o | output | 3 | Decoded enables, one-hot or zero |
| mux_o | output | 1 | Selected data bit, 0 on an unmapped address |

## Verification
Every time the inputs change, the assertions check several properties. Each decoder term must fire exactly when the address equals its code, so a swapped bit order or a wrong inversion is caught. The enable vector must stay one-hot or zero. The selector must follow the lane that is enabled and must give zero when no lane is enabled. Only the bench's scenarios can show that the map places codes 3, 6 and 7 on the right lanes and that every address/data pair gives the specified result. The bench also shows that the unselected data bits leave the output unchanged.

// File: rtl/sprs_pkg.sv
package sprs_pkg;
   localparam int unsigned SPRS_ADDR_W = 3;
   localparam int unsigned SPRS_LANES  = 3;
   // lane k code occupies bits [k*ADDR_W +: ADDR_W]
   localparam logic [SPRS_LANES*SPRS_ADDR_W-1:0] SPRS_CODES = {3'd7, 3'd6, 3'd3};

   function automatic logic [SPRS_ADDR_W-1:0] code_of(
      input logic [SPRS_LANES*SPRS_ADDR_W-1:0] codes,
      input int unsigned                       lane);
      return codes[lane*SPRS_ADDR_W +: SPRS_ADDR_W];
   endfunction
endpackage

// File: rtl/sprs_term.sv
module sprs_term #(
   parameter int unsigned          ADDR_W = 3,
   parameter logic [ADDR_W-1:0]    CODE   = '0
) (
   input  logic [ADDR_W-1:0] addr_i,
   output logic              hit_o
);
   logic [ADDR_W-1:0] lit;

   // one literal per address bit: true bit where the code holds 1, inverted bit where it holds 0
   for (genvar i = 0; i < ADDR_W; i++) begin : g_lit
      if (CODE[i]) begin : g_true
         assign lit[i] = addr_i[i];
      end else begin : g_inv
         assign lit[i] = ~addr_i[i];
      end
   end

   assign hit_o = &lit;

   always_comb begin
      AST_TERM_MATCH: assert (hit_o == (addr_i == CODE)); // R8
   end
endmodule

// File: rtl/sprs_sel.sv
module sprs_sel #(
   parameter int unsigned LANES = 3
) (
   input  logic [LANES-1:0] sel_i,
   input  logic [LANES-1:0] dat_i,
   output logic             out_o
);
   logic [LANES-1:0] prod;

   for (genvar k = 0; k < LANES; k++) begin : g_prod
      assign prod[k] = sel_i[k] & dat_i[k];
   end

   assign out_o = |prod;

   for (genvar k = 0; k < LANES; k++) begin : g_chk
      always_comb begin
         if (sel_i[k]) begin
            AST_SEL_PASS: assert (out_o == dat_i[k]); // R6
         end
      end
   end

   always_comb begin
      if (sel_i == '0) begin
         AST_SEL_IDLE: assert (out_o == 1'b0); // R5
      end
   end
endmodule

// File: rtl/sprs_dec_mux.sv
module sprs_dec_mux
   import sprs_pkg::*;
#(
   parameter int unsigned                 ADDR_W = SPRS_ADDR_W,
   parameter int unsigned                 LANES  = SPRS_LANES,
   parameter logic [LANES*ADDR_W-1:0]     CODES  = SPRS_CODES
) (
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [LANES-1:0]  dat_i,
   output logic [LANES-1:0]  en_o,
   output logic              mux_o
);
   localparam int unsigned SPACE = 1 << ADDR_W;

   // elaboration checks
   if (ADDR_W < 1 || ADDR_W > 16) begin : g_bad_w
      $error("sprs_dec_mux: ADDR_W out of range");
   end
   if (LANES < 1 || LANES > SPACE) begin : g_bad_lanes
      $error("sprs_dec_mux: LANES exceeds address space");
   end
   for (genvar i = 0; i < LANES; i++) begin : g_uniq_i
      for (genvar j = i + 1; j < LANES; j++) begin : g_uniq_j
         if (CODES[i*ADDR_W +: ADDR_W] == CODES[j*ADDR_W +: ADDR_W]) begin : g_dup
            $error("sprs_dec_mux: duplicate code");
         end
      end
   end

   // decoder: one minterm per mapped code
   for (genvar k = 0; k < LANES; k++) begin : g_dec
      sprs_term #(
         .ADDR_W (ADDR_W),
         .CODE   (CODES[k*ADDR_W +: ADDR_W])
      ) u_term (
         .addr_i (addr_i),
         .hit_o  (en_o[k])
      );
   end

   // selector: AND-OR over the enabled lanes
   sprs_sel #(
      .LANES (LANES)
   ) u_sel (
      .sel_i (en_o),
      .dat_i (dat_i),
      .out_o (mux_o)
   );

   always_comb begin
      AST_EN_ONEHOT0: assert ($onehot0(en_o)); // R4
   end
endmodule

// File: tb/tb_sprs_dec_mux.sv
module tb_sprs_dec_mux;
   localparam int CLK_PERIOD = 10;
   localparam int N_VEC      = 12;
   // vector: {addr[2:0], dat[2:0], exp_en[2:0], exp_mux}
   localparam logic [9:0] VEC [N_VEC] = '{
      {3'd3, 3'b001, 3'b001, 1'b1},
      {3'd3, 3'b110, 3'b001, 1'b0},
      {3'd6, 3'b010, 3'b010, 1'b1},
      {3'd6, 3'b101, 3'b010, 1'b0},
      {3'd7, 3'b100, 3'b100, 1'b1},
      {3'd7, 3'b011, 3'b100, 1'b0},
      {3'd0, 3'b111, 3'b000, 1'b0},
      {3'd1, 3'b111, 3'b000, 1'b0},
      {3'd2, 3'b111, 3'b000, 1'b0},
      {3'd4, 3'b111, 3'b000, 1'b0},
      {3'd5, 3'b111, 3'b000, 1'b0},
      {3'd7, 3'b111, 3'b100, 1'b1}
   };

   logic       clk = 1'b0;
   logic [2:0] addr;
   logic [2:0] dat;
   logic [2:0] en;
   logic       mux;
   int         n_chk  = 0;
   int         n_bad  = 0;
   bit         done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sprs_dec_mux dut (
      .addr_i (addr),
      .dat_i  (dat),
      .en_o   (en),
      .mux_o  (mux)
   );

   function automatic logic [2:0] ref_en(input logic [2:0] a);
      case (a)
         3'b011:  return 3'b001;
         3'b110:  return 3'b010;
         3'b111:  return 3'b100;
         default: return 3'b000;
      endcase
   endfunction

   function automatic logic ref_mux(input logic [2:0] a, input logic [2:0] d);
      case (a)
         3'b011:  return d[0];
         3'b110:  return d[1];
         3'b111:  return d[2];
         default: return 1'b0;
      endcase
   endfunction

   function automatic string tag_of(input logic [2:0] a);
      case (a)
         3'b011:  return "R1";
         3'b110:  return "R2";
         3'b111:  return "R3";
         default: return "R5";
      endcase
   endfunction

   task automatic apply(input logic [2:0] a, input logic [2:0] d);
      @(posedge clk);
      addr = a;
      dat  = d;
      @(negedge clk);
   endtask

   task automatic check(input string req, input logic [2:0] exp_e, input logic exp_m);
      n_chk++;
      if (en !== exp_e || mux !== exp_m) begin
         n_bad++;
         $display("FAIL %s addr=%0d dat=%b: en=%b mux=%b expected en=%b mux=%b",
                  req, addr, dat, en, mux, exp_e, exp_m);
      end
   endtask

   initial begin
      addr = 3'd0;
      dat  = 3'b111;
      @(negedge clk);
      check("R5 initial", 3'b000, 1'b0);

      // table walk
      for (int i = 0; i < N_VEC; i++) begin
         apply(VEC[i][9:7], VEC[i][6:4]);
         check({tag_of(VEC[i][9:7]), "/R6 table"}, VEC[i][3:1], VEC[i][0]);
      end

      // full sweep of address and data
      for (int a = 0; a < 8; a++) begin
         for (int d = 0; d < 8; d++) begin
            apply(3'(a), 3'(d));
            check({tag_of(3'(a)), "/R6 sweep"}, ref_en(3'(a)), ref_mux(3'(a), 3'(d)));
            n_chk++;
            if ($countones(en) > 1) begin
               n_bad++;
               $display("FAIL R4 addr=%0d: en=%b expected at most one bit set", a, en);
            end
         end
      end

      // R7: unselected lanes toggled at each mapped address
      apply(3'b011, 3'b001); check("R7 lane0 hold", 3'b001, 1'b1);
      apply(3'b011, 3'b111); check("R7 lane0 others up", 3'b001, 1'b1);
      apply(3'b011, 3'b110); check("R7 lane0 low", 3'b001, 1'b0);
      apply(3'b110, 3'b101); check("R7 lane1 others up", 3'b010, 1'b0);
      apply(3'b110, 3'b010); check("R7 lane1 alone", 3'b010, 1'b1);
      apply(3'b111, 3'b011); check("R7 lane2 others up", 3'b100, 1'b0);

      // R8: bit order, mirrored codes must stay unmapped
      apply(3'b001, 3'b111); check("R8 mirror of 4", 3'b000, 1'b0);
      apply(3'b100, 3'b111); check("R8 mirror of 1", 3'b000, 1'b0);
      apply(3'b110, 3'b001); check("R8 code6 vs 3", 3'b010, 1'b0);
      apply(3'b011, 3'b010); check("R8 code3 vs 6", 3'b001, 1'b0);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule